// File: doc/BRIEF.md
# Write-Protect / Power-Down Command Gate

This block sits between an ATA-style command decoder and the command executor. It watches one active-low pin, `guard_n`, whose meaning is chosen by a persistent mode bit. In guard mode (mode bit 0), an asserted pin blocks every destructive command. A blocked command completes at once with the fixed abort codes, and the executor never sees it. In sleep mode (mode bit 1), an asserted pin lets the current command run to completion. After that command the device goes to standby and ignores all further commands until a hard reset or a power-on reset.

The mode bit is kept in storage outside the block, which survives power loss and reset, and it reaches the gate on `mode_i`. A dedicated mode-select opcode updates that storage. The gate forwards the command to the executor and, in the same cycle, raises a one-cycle write pulse that carries the new mode value taken from bit 0 of the command argument. The pin passes through a synchronizer before any decision is made.

Top module: `wpd_cmd_gate`

## Requirements
- R1: While either reset is high, and in the cycle after it is released, `exec_o`, `rej_o`, `irq_o`, `mode_we_o` and `standby_o` are 0, `status_o` is 50h and `err_o` is 00h.
- R2: With `mode_i`=0 and the synchronized pin asserted (low), a strobed opcode from the set C0h, 50h, CAh, C5h, CDh, 30h, 31h, 38h, 3Ch is rejected. In the cycle after the strobe, `rej_o` and `irq_o` pulse for one cycle, `exec_o` stays 0, `status_o` becomes 51h and `err_o` becomes 04h.
- R3: With `mode_i`=0 and the pin asserted, any opcode outside that set is forwarded: `exec_o` pulses in the cycle after the strobe and `rej_o` stays 0.
- R4: With the pin deasserted (high), destructive opcodes are forwarded in either mode.
- R5: With `mode_i`=1, destructive opcodes are never rejected, whatever the pin level.
- R6: With `mode_i`=1, if the pin is asserted at the strobe or during the command, `standby_o` rises in the cycle after `cmd_done` and `irq_o` pulses in that same cycle.
- R7: While `standby_o` is 1, strobes produce no `exec_o`, `rej_o`, `irq_o` or `mode_we_o`, and `standby_o` stays 1.
- R8: Either `hard_rst` or `por_rst` clears `standby_o`, and commands are accepted again afterwards.
- R9: The mode-select opcode (parameter, default FAh) is forwarded with `exec_o`. In the same cycle, `mode_we_o` pulses and `mode_wd_o` equals bit 0 of `cmd_arg`. Reset issues no mode write, so a stored mode persists across resets.
- R10: A forwarded command restores `status_o` to 50h and `err_o` to 00h. `irq_o` pulses in the cycle after `cmd_done`.
- R11: With `mode_i`=1 and the pin deasserted for the whole command, `cmd_done` does not set `standby_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Hardware reset, synchronous, active high |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| guard_n | input | 1 | Asynchronous shared pin, active low |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_arg | input | 8 | Command argument (bit 0 = mode for mode-select) |
| cmd_done | input | 1 | Executor finished the forwarded command |
| mode_i | input | 1 | Stored mode: 0 guard, 1 sleep |
| exec_o | output | 1 | Forward pulse to the executor |
| rej_o | output | 1 | Reject pulse |
| irq_o | output | 1 | Interrupt request pulse |
| status_o | output | 8 | Status byte |
| err_o | output | 8 | Error byte |
| standby_o | output | 1 | Standby / lockout flag |
| mode_we_o | output | 1 | Mode storage write pulse |
| mode_wd_o | output | 1 | Mode value to store |

## Verification
The bench sends every destructive opcode under guard mode with the pin asserted. A decoder that misses one would forward it with `exec_o` instead of the abort codes. Read opcodes such as 20h and ECh are sent under the same conditions, to catch a decoder that blocks too widely. The bench asserts the pin only in the middle of a sleep-mode command, which catches a design that looks at the pin only at the strobe and so never locks. It then strobes while locked, which catches a design that leaks pulses, and sends a mode change followed by a reset, which catches a design that clears the stored mode on reset.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int OPW     = 8;
  localparam int N_DESTR = 9;
  localparam logic [OPW-1:0] DESTR_OPS [N_DESTR] = '{
    8'hC0, 8'h50, 8'hCA, 8'hC5, 8'hCD, 8'h30, 8'h31, 8'h38, 8'h3C};
  localparam logic [7:0] ST_READY = 8'h50;
  localparam logic [7:0] ST_ABORT = 8'h51;
  localparam logic [7:0] ER_NONE  = 8'h00;
  localparam logic [7:0] ER_ABORT = 8'h04;
  typedef enum logic {MODE_GUARD = 1'b0, MODE_SLEEP = 1'b1} gate_mode_e;
endpackage

// File: rtl/wpg_sync.sv
module wpg_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= INIT;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/wpg_classify.sv
module wpg_classify
  import wpg_pkg::*;
#(
  parameter logic [OPW-1:0] MODESEL_OP = 8'hFA
) (
  input  logic [OPW-1:0] op,
  output logic           destr,
  output logic           modesel
);
  logic [N_DESTR-1:0] hit;
  generate
    for (genvar i = 0; i < N_DESTR; i++) begin : g_cmp
      assign hit[i] = (op == DESTR_OPS[i]);
    end
  endgenerate
  assign destr   = |hit;
  assign modesel = (op == MODESEL_OP);
endmodule

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_act,
  input  logic       cmd_stb,
  input  logic       destr,
  input  logic       modesel,
  input  logic       arg_bit,
  input  logic       cmd_done,
  input  logic       mode_i,
  output logic       exec_o,
  output logic       rej_o,
  output logic       irq_o,
  output logic [7:0] status_o,
  output logic [7:0] err_o,
  output logic       standby_o,
  output logic       mode_we_o,
  output logic       mode_wd_o
);
  logic busy, pd_req;
  logic sleep_mode;
  assign sleep_mode = (gate_mode_e'(mode_i) == MODE_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pd_req    <= 1'b0;
      standby_o <= 1'b0;
      exec_o    <= 1'b0;
      rej_o     <= 1'b0;
      irq_o     <= 1'b0;
      mode_we_o <= 1'b0;
      mode_wd_o <= 1'b0;
      status_o  <= ST_READY;
      err_o     <= ER_NONE;
    end else begin
      exec_o    <= 1'b0;
      rej_o     <= 1'b0;
      irq_o     <= 1'b0;
      mode_we_o <= 1'b0;
      if (standby_o) begin
        busy   <= 1'b0;
        pd_req <= 1'b0;
      end else if (busy) begin
        if (sleep_mode && pin_act) pd_req <= 1'b1;
        if (cmd_done) begin
          busy   <= 1'b0;
          irq_o  <= 1'b1;
          pd_req <= 1'b0;
          if (pd_req || (sleep_mode && pin_act)) standby_o <= 1'b1;
        end
      end else if (cmd_stb) begin
        if (!sleep_mode && pin_act && destr) begin
          rej_o    <= 1'b1;
          irq_o    <= 1'b1;
          status_o <= ST_ABORT;
          err_o    <= ER_ABORT;
        end else begin
          exec_o   <= 1'b1;
          busy     <= 1'b1;
          status_o <= ST_READY;
          err_o    <= ER_NONE;
          pd_req   <= sleep_mode && pin_act;
          if (modesel) begin
            mode_we_o <= 1'b1;
            mode_wd_o <= arg_bit;
          end
        end
      end
    end
  end

  // R2: a reject carries the abort codes and an interrupt, never a forward
  a_r2_reject_codes: assert property (@(posedge clk) disable iff (rst)
    rej_o |-> (status_o == ST_ABORT && err_o == ER_ABORT && irq_o && !exec_o));
  // R7: lockout holds until reset
  a_r7_standby_holds: assert property (@(posedge clk) disable iff (rst)
    standby_o |=> standby_o);
  // R7: no activity while locked
  a_r7_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> (!exec_o && !rej_o && !mode_we_o));
  // R9: a mode write only accompanies a forwarded command
  a_r9_mode_with_exec: assert property (@(posedge clk) disable iff (rst)
    mode_we_o |-> exec_o);
  // R5: no rejection in sleep mode
  a_r5_no_reject_sleep: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && sleep_mode && !busy && !standby_o) |=> !rej_o);
endmodule

// File: rtl/wpd_cmd_gate.sv
module wpd_cmd_gate
  import wpg_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [OPW-1:0]  MODESEL_OP  = 8'hFA
) (
  input  logic           clk,
  input  logic           hard_rst,
  input  logic           por_rst,
  input  logic           guard_n,
  input  logic           cmd_stb,
  input  logic [OPW-1:0] cmd_op,
  input  logic [7:0]     cmd_arg,
  input  logic           cmd_done,
  input  logic           mode_i,
  output logic           exec_o,
  output logic           rej_o,
  output logic           irq_o,
  output logic [7:0]     status_o,
  output logic [7:0]     err_o,
  output logic           standby_o,
  output logic           mode_we_o,
  output logic           mode_wd_o
);
  logic rst, pin_sync, destr, modesel;
  assign rst = hard_rst | por_rst;

  wpg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(guard_n), .q(pin_sync));

  wpg_classify #(.MODESEL_OP(MODESEL_OP)) u_cls (
    .op(cmd_op), .destr(destr), .modesel(modesel));

  wpg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .pin_act(!pin_sync), .cmd_stb(cmd_stb),
    .destr(destr), .modesel(modesel), .arg_bit(cmd_arg[0]),
    .cmd_done(cmd_done), .mode_i(mode_i),
    .exec_o(exec_o), .rej_o(rej_o), .irq_o(irq_o),
    .status_o(status_o), .err_o(err_o), .standby_o(standby_o),
    .mode_we_o(mode_we_o), .mode_wd_o(mode_wd_o));
endmodule

// File: tb/sim_wpd_cmd_gate.sv
`timescale 1ns/1ps
module sim_wpd_cmd_gate;
  logic clk = 0, hard_rst = 1, por_rst = 0, guard_n = 1, cmd_stb = 0, cmd_done = 0;
  logic [7:0] cmd_op = 0, cmd_arg = 0;
  logic mode_nv = 0;
  logic exec_o, rej_o, irq_o, standby_o, mode_we_o, mode_wd_o;
  logic [7:0] status_o, err_o;
  int n_chk = 0, n_bad = 0;
  logic [7:0] destr_list [9] = '{8'hC0,8'h50,8'hCA,8'hC5,8'hCD,8'h30,8'h31,8'h38,8'h3C};

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (mode_we_o) mode_nv <= mode_wd_o;

  wpd_cmd_gate u0 (.clk, .hard_rst, .por_rst, .guard_n, .cmd_stb, .cmd_op, .cmd_arg,
    .cmd_done, .mode_i(mode_nv), .exec_o, .rej_o, .irq_o, .status_o, .err_o,
    .standby_o, .mode_we_o, .mode_wd_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_pin(logic v);
    @(negedge clk); guard_n = v;
    repeat (3) @(negedge clk);
  endtask

  // strobe; results sampled in the cycle after the strobe edge
  task automatic strobe(logic [7:0] op, logic [7:0] arg);
    @(negedge clk); cmd_op = op; cmd_arg = arg; cmd_stb = 1;
    @(negedge clk); cmd_stb = 0;
  endtask

  task automatic finish_cmd();
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
  endtask

  task automatic do_reset(bit por);
    @(negedge clk); if (por) por_rst = 1; else hard_rst = 1;
    @(negedge clk); por_rst = 0; hard_rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 exec", exec_o, 0); chk("R1 rej", rej_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 standby", standby_o, 0); chk("R1 mwe", mode_we_o, 0);
    chk("R1 status", status_o, 8'h50); chk("R1 err", err_o, 8'h00);
  endtask

  task automatic t_mode(logic m);
    strobe(8'hFA, {7'd0, m});
    chk("R9 exec", exec_o, 1); chk("R9 mwe", mode_we_o, 1); chk("R9 mwd", mode_wd_o, m);
    finish_cmd();
  endtask

  task automatic t_guard_reject();
    set_pin(0);
    foreach (destr_list[i]) begin
      strobe(destr_list[i], 0);
      chk("R2 rej", rej_o, 1); chk("R2 exec", exec_o, 0); chk("R2 irq", irq_o, 1);
      chk("R2 status", status_o, 8'h51); chk("R2 err", err_o, 8'h04);
      @(negedge clk);
      chk("R2 one-cycle", rej_o, 0);
    end
  endtask

  task automatic t_guard_pass();
    logic [7:0] safe [3] = '{8'h20, 8'hEC, 8'hE5};
    foreach (safe[i]) begin
      strobe(safe[i], 0);
      chk("R3 exec", exec_o, 1); chk("R3 rej", rej_o, 0);
      chk("R10 status", status_o, 8'h50); chk("R10 err", err_o, 8'h00);
      finish_cmd();
      chk("R10 irq", irq_o, 1);
    end
    set_pin(1);
    strobe(8'h30, 0);
    chk("R4 exec", exec_o, 1); chk("R4 rej", rej_o, 0);
    finish_cmd();
  endtask

  task automatic t_sleep_idle();
    strobe(8'hCA, 0);
    chk("R4 exec sleep", exec_o, 1);
    finish_cmd();
    chk("R11 no standby", standby_o, 0);
  endtask

  task automatic t_sleep_lock(bit por);
    strobe(8'h30, 0);
    chk("R5 exec", exec_o, 1); chk("R5 rej", rej_o, 0);
    set_pin(0);
    set_pin(1);
    chk("R6 not yet", standby_o, 0);
    finish_cmd();
    chk("R6 standby", standby_o, 1); chk("R6 irq", irq_o, 1);
    strobe(8'h20, 0);
    chk("R7 exec", exec_o, 0); chk("R7 irq", irq_o, 0); chk("R7 rej", rej_o, 0);
    strobe(8'hFA, 8'h00);
    chk("R7 mwe", mode_we_o, 0); chk("R7 standby", standby_o, 1);
    do_reset(por);
    chk("R8 released", standby_o, 0);
    strobe(8'h20, 0);
    chk("R8 accepts", exec_o, 1);
    finish_cmd();
  endtask

  task automatic t_persist();
    set_pin(0);
    strobe(8'hC5, 0);
    chk("R9 persist no rej", rej_o, 0); chk("R5 exec pinlow", exec_o, 1);
    finish_cmd();
    chk("R6 at-strobe lock", standby_o, 1);
    set_pin(1);
    do_reset(0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        hard_rst = 0;
        chk("R1 in reset", standby_o, 0);
        @(negedge clk);
        t_reset();
        t_mode(0);
        t_guard_reject();
        t_guard_pass();
        t_mode(1);
        chk("R9 stored", mode_nv, 1);
        t_sleep_idle();
        t_sleep_lock(0);
        t_sleep_lock(1);
        t_persist();
        chk("R9 after reset", mode_nv, 1);
        t_mode(0);
        set_pin(0);
        strobe(8'h3C, 0);
        chk("R2 back to guard", rej_o, 1);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule